// File: doc/BRIEF.md
# Dual 16-bit Multiply-Accumulate Unit

This block holds two independent multiply-accumulate lanes. On each cycle with `in_valid` high, every lane takes one 16-bit operand from the upper or lower half of the 32-bit word `src_a` and another from `src_b`. It multiplies them and either loads the product into its own 40-bit accumulator, adds it, or subtracts it. The accumulator has 8 guard bits above the 32-bit product width. Each lane keeps a sticky overflow flag that records any wrap of the 40-bit accumulator.

The read-out of each lane has two forms. One is the raw 40-bit accumulator. The other is a 32-bit result taken from it. That result is either a 16-bit word from accumulator bits 31:16, optionally rounded to nearest and sign-extended, or the low 32 bits. Each form can be clamped to the signed limits of its width. The read-out mode is taken from the operation, so each lane remembers the flags that came with its last valid operation.

Top module: `dmac_top`

## Requirements
- R1: After a synchronous reset, both accumulators, both overflow flags, both results and `out_vld` are zero.
- R2: A lane's `sel_a`/`sel_b` bit (lane i is bit i) selects the upper half [31:16] of the source word when 1 and the lower half [15:0] when 0.
- R3: Lane i's code `op[2i+1:2i]` with `in_valid` high: 00 replaces the accumulator with the product, 01 adds the product, 10 subtracts it, 11 keeps the accumulator. The new value is visible after the next clock edge.
- R4: With `is_signed`=1 both operands are two's complement; with 0 both are unsigned. The product is extended to 40 bits accordingly.
- R5: While `in_valid` is low, accumulators, overflow flags and results do not change, whatever the other inputs carry.
- R6: A lane's overflow flag is set when an add or subtract wraps the signed 40-bit accumulator. It stays set until that lane is cleared.
- R7: `clr[i]` zeroes lane i's accumulator, overflow flag and read-out mode. It takes priority over an operation in the same cycle and leaves the other lane alone.
- R8: In narrow mode (`wide_en`=0) the result is accumulator bits 31:16, sign-extended to 32 bits. With `rnd_en`=1, 0x8000 is first added to the accumulator.
- R9: In narrow mode with `sat_en`=1, a (rounded) value outside the signed 16-bit range gives 0x00007FFF or 0xFFFF8000.
- R10: In wide mode the result is accumulator bits 31:0 and `rnd_en` has no effect. With `sat_en`=1, if bits 39:31 are not all equal the result is 0x7FFFFFFF or 0x80000000 by the sign.
- R11: The flags `rnd_en`, `sat_en` and `wide_en` are captured per lane on every valid operation, including code 11. The result keeps following them until the next one.
- R12: `out_vld` is high exactly one cycle after each cycle with `in_valid` high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand and command strobe |
| src_a | input | 32 | First source word |
| src_b | input | 32 | Second source word |
| sel_a | input | 2 | Half select for operand A, one bit per lane |
| sel_b | input | 2 | Half select for operand B, one bit per lane |
| op | input | 4 | Two-bit operation code per lane |
| is_signed | input | 1 | Operand format: 1 signed, 0 unsigned |
| rnd_en | input | 1 | Round-to-nearest for narrow read-out |
| sat_en | input | 1 | Saturate the read-out |
| wide_en | input | 1 | 32-bit read-out when 1, 16-bit when 0 |
| clr | input | 2 | Per-lane clear |
| acc_out | output | 80 | Accumulators, lane i at [40i+39:40i] |
| res_out | output | 64 | Extracted results, lane i at [32i+31:32i] |
| ovf | output | 2 | Sticky overflow per lane |
| out_vld | output | 1 | Result strobe, one cycle after in_valid |

## Verification
The hardest state to reach is a real wrap of the 40-bit accumulator. The guard bits absorb hundreds of maximum-size products before bit 39 is reached. The bench builds toward it with the largest product the unit can form, (-32768)×(-32768) = 2^30. It loads that product and then adds it again 511 times. After 510 adds it checks that the accumulator is at 0x7FC0000000 with the flag still clear. It then checks that the next add wraps to 0x8000000000 and sets the flag. A following subtract wraps back the other way and must leave the flag set. Saturation of both read-out widths is reached more cheaply, with three products of 0x7FFF×0x7FFF accumulated and subtracted.

// File: rtl/dmac_pkg.sv
package dmac_pkg;

  typedef enum logic [1:0] {
    MAC_LOAD = 2'b00,
    MAC_ADD  = 2'b01,
    MAC_SUB  = 2'b10,
    MAC_KEEP = 2'b11
  } mac_op_e;

  typedef struct packed {
    logic rnd;
    logic sat;
    logic wide;
  } xmode_t;

endpackage

// File: rtl/dmac_opsel.sv
module dmac_opsel #(
  parameter int OP_W = 16
) (
  input  logic [2*OP_W-1:0] word_a,
  input  logic [2*OP_W-1:0] word_b,
  input  logic              hi_a,
  input  logic              hi_b,
  output logic [OP_W-1:0]   opnd_a,
  output logic [OP_W-1:0]   opnd_b
);
  always_comb begin
    opnd_a = hi_a ? word_a[2*OP_W-1:OP_W] : word_a[OP_W-1:0];
    opnd_b = hi_b ? word_b[2*OP_W-1:OP_W] : word_b[OP_W-1:0];
  end
endmodule

// File: rtl/dmac_mult.sv
module dmac_mult #(
  parameter int OP_W  = 16,
  parameter int ACC_W = 40
) (
  input  logic [OP_W-1:0]  a,
  input  logic [OP_W-1:0]  b,
  input  logic             sgn,
  output logic [ACC_W-1:0] prod
);
  localparam int XW = OP_W + 1;
  localparam int PW = 2 * XW;
  localparam int GUARD = ACC_W - PW;

  logic signed [XW-1:0] xa, xb;
  logic signed [PW-1:0] p;

  always_comb begin
    xa = $signed({sgn & a[OP_W-1], a});
    xb = $signed({sgn & b[OP_W-1], b});
    p  = xa * xb;
  end

  generate
    if (GUARD > 0) begin : g_ext
      assign prod = {{GUARD{p[PW-1]}}, p};
    end else begin : g_trunc
      assign prod = p[ACC_W-1:0];
    end
  endgenerate
endmodule

// File: rtl/dmac_extract.sv
module dmac_extract #(
  parameter int OP_W  = 16,
  parameter int ACC_W = 40
) (
  input  logic [ACC_W-1:0]  acc,
  input  dmac_pkg::xmode_t  mode,
  output logic [2*OP_W-1:0] res
);
  localparam int RES_W = 2 * OP_W;
  localparam int TW    = ACC_W + 1 - OP_W;

  logic [ACC_W:0]    rounded;
  logic [ACC_W:0]    rconst;
  logic [TW-1:0]     top;
  logic [TW-OP_W:0]  nhead;
  logic [ACC_W-RES_W:0] whead;
  logic              nfit, wfit;
  logic [OP_W-1:0]   nval;
  logic [RES_W-1:0]  wval;

  always_comb begin
    rconst = '0;
    rconst[OP_W-1] = mode.rnd;
    rounded = {acc[ACC_W-1], acc} + rconst;
    top   = rounded[ACC_W:OP_W];
    nhead = top[TW-1:OP_W-1];
    nfit  = (&nhead) | ~(|nhead);
    if (mode.sat && !nfit)
      nval = top[TW-1] ? {1'b1, {(OP_W-1){1'b0}}} : {1'b0, {(OP_W-1){1'b1}}};
    else
      nval = top[OP_W-1:0];

    whead = acc[ACC_W-1:RES_W-1];
    wfit  = (&whead) | ~(|whead);
    if (mode.sat && !wfit)
      wval = acc[ACC_W-1] ? {1'b1, {(RES_W-1){1'b0}}} : {1'b0, {(RES_W-1){1'b1}}};
    else
      wval = acc[RES_W-1:0];

    res = mode.wide ? wval : {{OP_W{nval[OP_W-1]}}, nval};
  end
endmodule

// File: rtl/dmac_lane.sv
module dmac_lane
  import dmac_pkg::*;
#(
  parameter int OP_W  = 16,
  parameter int ACC_W = 40
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              valid,
  input  logic              clr,
  input  mac_op_e           op,
  input  logic [OP_W-1:0]   a,
  input  logic [OP_W-1:0]   b,
  input  logic              sgn,
  input  xmode_t            mode_in,
  output logic [ACC_W-1:0]  acc,
  output logic [2*OP_W-1:0] res,
  output logic              ovf
);
  logic [ACC_W-1:0] prod, sum, diff, nxt;
  logic             wrap;
  xmode_t           mode_q;

  dmac_mult #(.OP_W(OP_W), .ACC_W(ACC_W)) u_mult (
    .a(a), .b(b), .sgn(sgn), .prod(prod)
  );

  always_comb begin
    sum  = acc + prod;
    diff = acc - prod;
    nxt  = acc;
    wrap = 1'b0;
    unique case (op)
      MAC_LOAD: nxt = prod;
      MAC_ADD: begin
        nxt  = sum;
        wrap = (acc[ACC_W-1] == prod[ACC_W-1]) && (sum[ACC_W-1] != acc[ACC_W-1]);
      end
      MAC_SUB: begin
        nxt  = diff;
        wrap = (acc[ACC_W-1] != prod[ACC_W-1]) && (diff[ACC_W-1] != acc[ACC_W-1]);
      end
      default: nxt = acc;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      acc    <= '0;
      ovf    <= 1'b0;
      mode_q <= '0;
    end else if (valid) begin
      acc    <= nxt;
      ovf    <= ovf | wrap;
      mode_q <= mode_in;
    end
  end

  dmac_extract #(.OP_W(OP_W), .ACC_W(ACC_W)) u_ext (
    .acc(acc), .mode(mode_q), .res(res)
  );
endmodule

// File: rtl/dmac_top.sv
module dmac_top
  import dmac_pkg::*;
#(
  parameter int NL    = 2,
  parameter int OP_W  = 16,
  parameter int ACC_W = 40
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   in_valid,
  input  logic [2*OP_W-1:0]      src_a,
  input  logic [2*OP_W-1:0]      src_b,
  input  logic [NL-1:0]          sel_a,
  input  logic [NL-1:0]          sel_b,
  input  logic [2*NL-1:0]        op,
  input  logic                   is_signed,
  input  logic                   rnd_en,
  input  logic                   sat_en,
  input  logic                   wide_en,
  input  logic [NL-1:0]          clr,
  output logic [NL*ACC_W-1:0]    acc_out,
  output logic [NL*2*OP_W-1:0]   res_out,
  output logic [NL-1:0]          ovf,
  output logic                   out_vld
);
  localparam int RES_W = 2 * OP_W;

  xmode_t mode_in;
  assign mode_in = '{rnd: rnd_en, sat: sat_en, wide: wide_en};

  generate
    for (genvar i = 0; i < NL; i++) begin : g_lane
      logic [OP_W-1:0] oa, ob;

      dmac_opsel #(.OP_W(OP_W)) u_sel (
        .word_a(src_a), .word_b(src_b),
        .hi_a(sel_a[i]), .hi_b(sel_b[i]),
        .opnd_a(oa), .opnd_b(ob)
      );

      dmac_lane #(.OP_W(OP_W), .ACC_W(ACC_W)) u_lane (
        .clk(clk), .rst(rst), .valid(in_valid), .clr(clr[i]),
        .op(mac_op_e'(op[2*i +: 2])),
        .a(oa), .b(ob), .sgn(is_signed), .mode_in(mode_in),
        .acc(acc_out[i*ACC_W +: ACC_W]),
        .res(res_out[i*RES_W +: RES_W]),
        .ovf(ovf[i])
      );
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) out_vld <= 1'b0;
    else     out_vld <= in_valid;
  end
endmodule

// File: rtl/dmac_chk.sv
module dmac_chk #(
  parameter int NL    = 2,
  parameter int OP_W  = 16,
  parameter int ACC_W = 40
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 in_valid,
  input logic                 wide_en,
  input logic [NL-1:0]        clr,
  input logic [NL*ACC_W-1:0]  acc_out,
  input logic [NL*2*OP_W-1:0] res_out,
  input logic [NL-1:0]        ovf,
  input logic                 out_vld
);
  localparam int RES_W = 2 * OP_W;

  p_vld_hi_r12: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_vld);
  p_vld_lo_r12: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_vld);

  generate
    for (genvar i = 0; i < NL; i++) begin : g_chk
      p_idle_r5: assert property (@(posedge clk) disable iff (rst)
        (!in_valid && !clr[i]) |=> ($stable(acc_out[i*ACC_W +: ACC_W]) && $stable(ovf[i])
                                    && $stable(res_out[i*RES_W +: RES_W])));
      p_sticky_r6: assert property (@(posedge clk) disable iff (rst)
        (ovf[i] && !clr[i]) |=> ovf[i]);
      p_clear_r7: assert property (@(posedge clk) disable iff (rst)
        clr[i] |=> (acc_out[i*ACC_W +: ACC_W] == '0 && !ovf[i]));
      p_narrow_r8: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !wide_en) |=>
          (res_out[i*RES_W + OP_W - 1 +: OP_W + 1] == '0 ||
           &res_out[i*RES_W + OP_W - 1 +: OP_W + 1]));
    end
  endgenerate
endmodule

bind dmac_top dmac_chk #(.NL(NL), .OP_W(OP_W), .ACC_W(ACC_W)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .wide_en(wide_en), .clr(clr),
  .acc_out(acc_out), .res_out(res_out), .ovf(ovf), .out_vld(out_vld)
);

// File: tb/tb_dmac_top.sv
module tb_dmac_top;
  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic [31:0] src_a, src_b;
  logic [1:0]  sel_a, sel_b;
  logic [3:0]  op;
  logic        is_signed, rnd_en, sat_en, wide_en;
  logic [1:0]  clr;
  logic [79:0] acc_out;
  logic [63:0] res_out;
  logic [1:0]  ovf;
  logic        out_vld;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  dmac_top dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .src_a(src_a), .src_b(src_b),
    .sel_a(sel_a), .sel_b(sel_b), .op(op), .is_signed(is_signed),
    .rnd_en(rnd_en), .sat_en(sat_en), .wide_en(wide_en), .clr(clr),
    .acc_out(acc_out), .res_out(res_out), .ovf(ovf), .out_vld(out_vld)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [39:0] acc(input int i);
    return acc_out[i*40 +: 40];
  endfunction

  function automatic logic [31:0] res(input int i);
    return res_out[i*32 +: 32];
  endfunction

  // drive one cycle at negedge, sample at the following negedge
  task automatic step(input logic v, input logic [3:0] o, input logic [1:0] c);
    in_valid = v; op = o; clr = c;
    @(negedge clk);
    in_valid = 1'b0; clr = 2'b00;
  endtask

  task automatic t_reset;
    chk("R1 acc0", acc(0), 0);
    chk("R1 acc1", acc(1), 0);
    chk("R1 ovf", ovf, 0);
    chk("R1 res", res_out, 0);
    chk("R1 vld", out_vld, 0);
  endtask

  task automatic t_load_halves;
    src_a = 32'h0005_FFFD; src_b = 32'h0007_0002;
    sel_a = 2'b10; sel_b = 2'b01; is_signed = 1'b1;
    step(1'b1, 4'b0000, 2'b00);
    chk("R2 R4 lane0 -3*7", acc(0), 40'hFF_FFFF_FFEB);
    chk("R2 lane1 5*2", acc(1), 40'h0A);
    chk("R12 vld after strobe", out_vld, 1);
    step(1'b1, 4'b1001, 2'b00);
    chk("R3 add lane0", acc(0), 40'hFF_FFFF_FFD6);
    chk("R3 sub lane1", acc(1), 40'h0);
  endtask

  task automatic t_idle;
    src_a = 32'h1234_5678; src_b = 32'h7FFF_7FFF;
    for (int k = 0; k < 3; k++) step(1'b0, 4'b0000, 2'b00);
    chk("R5 idle acc0", acc(0), 40'hFF_FFFF_FFD6);
    chk("R5 idle acc1", acc(1), 40'h0);
    chk("R12 vld low when idle", out_vld, 0);
  endtask

  task automatic t_signedness;
    src_a = 32'hFFFF_FFFF; src_b = 32'hFFFF_FFFF; sel_a = 2'b00; sel_b = 2'b00;
    is_signed = 1'b0;
    step(1'b1, 4'b0000, 2'b00);
    chk("R4 unsigned lane0", acc(0), 40'h00_FFFE_0001);
    chk("R4 unsigned lane1", acc(1), 40'h00_FFFE_0001);
    is_signed = 1'b1;
    step(1'b1, 4'b0000, 2'b00);
    chk("R4 signed lane0", acc(0), 40'h1);
    chk("R4 signed lane1", acc(1), 40'h1);
  endtask

  task automatic t_round;
    sel_a = 2'b00; sel_b = 2'b00; is_signed = 1'b1;
    rnd_en = 0; sat_en = 0; wide_en = 0;
    src_a = 32'h0000_0180; src_b = 32'h0000_0100;
    step(1'b1, 4'b1100, 2'b00);
    chk("R8 acc 0x18000", acc(0), 40'h1_8000);
    chk("R8 truncate", res(0), 32'h1);
    rnd_en = 1;
    step(1'b1, 4'b1111, 2'b00);
    chk("R11 keep op leaves acc", acc(0), 40'h1_8000);
    chk("R8 R11 round up", res(0), 32'h2);
    src_a = 32'h0000_7FFF; src_b = 32'h0000_0003;
    step(1'b1, 4'b1100, 2'b00);
    chk("R8 round below half", res(0), 32'h1);
    src_a = 32'h0000_FE80; src_b = 32'h0000_0100; rnd_en = 0;
    step(1'b1, 4'b1100, 2'b00);
    chk("R8 negative acc", acc(0), 40'hFF_FFFE_8000);
    chk("R8 negative truncate", res(0), 32'hFFFF_FFFE);
    rnd_en = 1;
    step(1'b1, 4'b1111, 2'b00);
    chk("R8 negative round", res(0), 32'hFFFF_FFFF);
  endtask

  task automatic t_saturate;
    rnd_en = 0; sat_en = 0; wide_en = 0;
    src_a = 32'h0000_7FFF; src_b = 32'h0000_7FFF;
    step(1'b1, 4'b1100, 2'b00);
    step(1'b1, 4'b1101, 2'b00);
    step(1'b1, 4'b1101, 2'b00);
    chk("R3 three products", acc(0), 40'h00_BFFD_0003);
    chk("R9 narrow wraps w/o sat", res(0), 32'hFFFF_BFFD);
    sat_en = 1;
    step(1'b1, 4'b1111, 2'b00);
    chk("R9 narrow clamp high", res(0), 32'h0000_7FFF);
    wide_en = 1; sat_en = 0;
    step(1'b1, 4'b1111, 2'b00);
    chk("R10 wide raw", res(0), 32'hBFFD_0003);
    rnd_en = 1;
    step(1'b1, 4'b1111, 2'b00);
    chk("R10 wide ignores round", res(0), 32'hBFFD_0003);
    rnd_en = 0; sat_en = 1;
    step(1'b1, 4'b1111, 2'b00);
    chk("R10 wide clamp high", res(0), 32'h7FFF_FFFF);
    step(1'b0, 4'b1111, 2'b01);
    chk("R7 clear acc0", acc(0), 40'h0);
    chk("R7 lane1 untouched", acc(1), 40'h1);
    chk("R7 R11 mode cleared", res(0), 32'h0);
    sat_en = 0; wide_en = 0;
    for (int k = 0; k < 3; k++) step(1'b1, 4'b1110, 2'b00);
    chk("R3 three subtracts", acc(0), 40'hFF_4002_FFFD);
    chk("R8 narrow negative raw", res(0), 32'h0000_4002);
    sat_en = 1;
    step(1'b1, 4'b1111, 2'b00);
    chk("R9 narrow clamp low", res(0), 32'hFFFF_8000);
    wide_en = 1;
    step(1'b1, 4'b1111, 2'b00);
    chk("R10 wide clamp low", res(0), 32'h8000_0000);
    chk("R6 no wrap yet", ovf, 2'b00);
  endtask

  task automatic t_clr_priority;
    rnd_en = 0; sat_en = 0; wide_en = 0;
    src_a = 32'h0000_0002; src_b = 32'h0000_0003;
    step(1'b1, 4'b0000, 2'b01);
    chk("R7 clear beats load", acc(0), 40'h0);
    chk("R7 other lane loads", acc(1), 40'h6);
  endtask

  task automatic t_overflow;
    src_a = 32'h8000_8000; src_b = 32'h8000_8000; is_signed = 1;
    step(1'b1, 4'b1100, 2'b00);
    for (int k = 0; k < 510; k++) step(1'b1, 4'b1101, 2'b00);
    chk("R6 near limit", acc(0), 40'h7F_C000_0000);
    chk("R6 flag clear before wrap", ovf, 2'b00);
    step(1'b1, 4'b1101, 2'b00);
    chk("R6 wrapped value", acc(0), 40'h80_0000_0000);
    chk("R6 flag set, lane1 clear", ovf, 2'b01);
    step(1'b1, 4'b1110, 2'b00);
    chk("R6 wrap back", acc(0), 40'h7F_C000_0000);
    step(1'b1, 4'b1110, 2'b00);
    chk("R6 sticky", ovf, 2'b01);
    for (int k = 0; k < 4; k++) step(1'b0, 4'b1101, 2'b00);
    chk("R5 R6 flag held idle", ovf, 2'b01);
    chk("R5 lane1 kept", acc(1), 40'h6);
    step(1'b0, 4'b1111, 2'b01);
    chk("R7 R6 flag cleared", ovf, 2'b00);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst = 1; in_valid = 0; src_a = 0; src_b = 0; sel_a = 0; sel_b = 0;
    op = 0; is_signed = 0; rnd_en = 0; sat_en = 0; wide_en = 0; clr = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_load_halves();
    t_idle();
    t_signedness();
    t_round();
    t_saturate();
    t_clr_priority();
    t_overflow();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule